// File: doc/BRIEF.md
# Warp Shared-Memory Bank Transaction Splitter

This block takes one warp-wide shared-memory request and breaks it into a sequence of bank transactions that are free of conflicts. The request has 32 lanes. Each lane has a byte address and an active bit. The request as a whole carries one access width (32, 64 or 128 bits) and one read/write flag. The memory behind the block has 32 banks, and each bank is one 32-bit word wide. In a single transaction each bank can open exactly one word row, so at most 128 unique bytes move per cycle. Any number of lanes that want the same word share it through broadcast.

After a request is accepted, the block drives one transaction per cycle. Each transaction gives the mask of lanes it serves, and for every bank an enable, the row to open and the lane that owns the bank's word (that lane is the data source for writes). A 128-bit access runs as two half-warp passes, lanes 0-15 first and then lanes 16-31, so it always costs at least two transactions. When all active lanes have been served, a one-cycle done pulse reports how many transactions were used. The block does not hold any data storage.

Top module: `wss_splitter`

## Requirements
- R1: The bank is byte-address bits [6:2] and the row is bits [15:7]. A 64-bit access covers banks {b&~1, (b&~1)+1}, a 128-bit access covers banks (b&~3) through (b&~3)+3, and all of them use the same row. Address bits below the access size have no effect. Width codes are 0 for 32-bit, 1 for 64-bit and 2 for 128-bit, and code 3 acts as 32-bit.
- R2: Lanes whose words coincide are served in the same transaction. When every lane targets one word, a single transaction serves all lanes in scope.
- R3: Pending lanes are visited in ascending order. A lane joins the current transaction only if each bank it needs is either unclaimed or already claimed with the same row. A bank never opens more than one row per transaction, and the lowest pending lane in scope is always served.
- R4: For each enabled bank, the source lane is the lowest-numbered lane served in that transaction that touches the bank. When several lanes write one address, that lane alone supplies the write.
- R5: A 128-bit request with any active lane serves lanes 0-15 first and lanes 16-31 second. Each half takes at least one transaction, and a half with no active lanes produces one transaction with an empty lane mask and no banks enabled.
- R6: A 128-bit request in which lane i has address i*16 takes exactly 4 transactions.
- R7: A 64-bit request costs the same as the 32-bit pattern over the same words. For example, lane i at address i*8 takes 2 transactions.
- R8: Inactive lanes are ignored. A request with no active lanes produces no transaction and pulses done in the cycle after acceptance, with a count of 0.
- R9: Ready stays low from acceptance until the split ends. Transactions appear one per cycle starting the cycle after acceptance, and no lane is served twice. Done pulses in the cycle after the last transaction, and the count equals the number of transactions.
- R10: After reset, ready is high and both transaction-valid and done are low.
- R11: The transaction write flag equals the accepted request's write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter idle, request accepted on valid |
| req_active | input | 32 | Per-lane active bits |
| req_addr | input | 512 | Lane byte addresses, lane l at [16l+15:16l] |
| req_width | input | 2 | Access width code |
| req_write | input | 1 | 1 for write, 0 for read |
| txn_valid | output | 1 | A transaction is presented this cycle |
| txn_lanes | output | 32 | Lanes served by this transaction |
| txn_bank_en | output | 32 | Banks opened by this transaction |
| txn_bank_row | output | 288 | Row per bank, bank b at [9b+8:9b] |
| txn_bank_src | output | 160 | Source lane per bank, bank b at [5b+4:5b] |
| txn_write | output | 1 | Write flag of the transaction |
| done | output | 1 | One-cycle pulse at the end of a split |
| done_count | output | 6 | Transactions used, valid with done |

## Verification
The assertions assume that the requester leaves req_valid low, or that its offer is ignored, while ready is low. They also assume that a request's width code stays fixed for the whole split, which holds because the block captures the request at acceptance. The stimulus offers requests only while ready is high, drops valid right after acceptance, and sweeps lane strides for every width. Under that stimulus the served lanes, rows and counts all follow from gcd arithmetic.

// File: rtl/wss_pkg.sv
package wss_pkg;
   typedef enum logic [1:0] {
      ACC_W32  = 2'd0,
      ACC_W64  = 2'd1,
      ACC_W128 = 2'd2,
      ACC_RSVD = 2'd3
   } acc_width_e;
endpackage

// File: rtl/wss_lane_map.sv
// Maps one lane's byte address to the set of banks it touches and its row.
module wss_lane_map #(
   parameter int BANKS  = 32,
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0]                      addr,
   input  wss_pkg::acc_width_e                    width,
   output logic [BANKS-1:0]                       banks,
   output logic [ADDR_W-$clog2(BANKS)-3:0]        row
);
   localparam int BANK_W = $clog2(BANKS);

   logic [BANK_W-1:0] bidx;
   logic              unused_lowbits;

   assign bidx           = addr[BANK_W+1:2];
   assign row            = addr[ADDR_W-1:BANK_W+2];
   assign unused_lowbits = ^addr[1:0];

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      localparam logic [BANK_W-1:0] BID = BANK_W'(b);
      always_comb begin
         unique case (width)
            wss_pkg::ACC_W64:  banks[b] = (BID[BANK_W-1:1] == bidx[BANK_W-1:1]);
            wss_pkg::ACC_W128: banks[b] = (BID[BANK_W-1:2] == bidx[BANK_W-1:2]);
            default:           banks[b] = (BID == bidx);
         endcase
      end
   end
endmodule

// File: rtl/wss_pick.sv
// Greedy lane-ordered selection of one conflict-free transaction.
module wss_pick #(
   parameter int LANES = 32,
   parameter int BANKS = 32,
   parameter int ROW_W = 9
) (
   input  logic [LANES-1:0]                         cand,
   input  logic [LANES-1:0][BANKS-1:0]              lane_banks,
   input  logic [LANES-1:0][ROW_W-1:0]              lane_rows,
   output logic [LANES-1:0]                         served,
   output logic [BANKS-1:0]                         bank_en,
   output logic [BANKS-1:0][ROW_W-1:0]              bank_row,
   output logic [BANKS-1:0][$clog2(LANES)-1:0]      bank_src
);
   localparam int LANE_W = $clog2(LANES);

   logic fit;

   always_comb begin
      served   = '0;
      bank_en  = '0;
      bank_row = '0;
      bank_src = '0;
      fit      = 1'b1;
      for (int l = 0; l < LANES; l++) begin
         if (cand[l]) begin
            fit = 1'b1;
            for (int b = 0; b < BANKS; b++) begin
               if (lane_banks[l][b] && bank_en[b] && (bank_row[b] != lane_rows[l]))
                  fit = 1'b0;
            end
            if (fit) begin
               served[l] = 1'b1;
               for (int b = 0; b < BANKS; b++) begin
                  if (lane_banks[l][b] && !bank_en[b]) begin
                     bank_en[b]  = 1'b1;
                     bank_row[b] = lane_rows[l];
                     bank_src[b] = LANE_W'(l);
                  end
               end
            end
         end
      end
   end
endmodule

// File: rtl/wss_splitter.sv
module wss_splitter #(
   parameter int LANES  = 32,
   parameter int BANKS  = 32,
   parameter int ADDR_W = 16
) (
   input  logic                                        clk,
   input  logic                                        rst_n,
   input  logic                                        req_valid,
   output logic                                        req_ready,
   input  logic [LANES-1:0]                            req_active,
   input  logic [LANES*ADDR_W-1:0]                     req_addr,
   input  logic [1:0]                                  req_width,
   input  logic                                        req_write,
   output logic                                        txn_valid,
   output logic [LANES-1:0]                            txn_lanes,
   output logic [BANKS-1:0]                            txn_bank_en,
   output logic [BANKS*(ADDR_W-$clog2(BANKS)-2)-1:0]   txn_bank_row,
   output logic [BANKS*$clog2(LANES)-1:0]              txn_bank_src,
   output logic                                        txn_write,
   output logic                                        done,
   output logic [$clog2(LANES+1)-1:0]                  done_count
);
   import wss_pkg::*;

   localparam int BANK_W = $clog2(BANKS);
   localparam int ROW_W  = ADDR_W - BANK_W - 2;
   localparam int LANE_W = $clog2(LANES);
   localparam int CNT_W  = $clog2(LANES+1);
   localparam int HALF   = LANES / 2;
   localparam logic [LANES-1:0] LO_MASK = {{(LANES-HALF){1'b0}}, {HALF{1'b1}}};

   initial begin
      a_banks_pow2: assert (BANKS >= 4 && (BANKS & (BANKS-1)) == 0)
         else $error("BANKS must be a power of two of at least 4");
      a_lanes_even: assert (LANES >= 2 && LANES % 2 == 0)
         else $error("LANES must be even");
      a_addr_room: assert (ADDR_W > BANK_W + 2)
         else $error("ADDR_W leaves no row bits");
   end

   logic                     busy_q, pass_q, write_q, done_q;
   acc_width_e               width_q;
   logic [LANES-1:0]         pend_q;
   logic [LANES*ADDR_W-1:0]  addr_q;
   logic [CNT_W-1:0]         cnt_q, done_cnt_q;

   logic [LANES-1:0][BANKS-1:0] lane_banks;
   logic [LANES-1:0][ROW_W-1:0] lane_rows;
   logic [LANES-1:0]            scope, cand, served;
   logic [BANKS-1:0]            bank_en;
   logic [BANKS-1:0][ROW_W-1:0] bank_row;
   logic [BANKS-1:0][LANE_W-1:0] bank_src;
   logic                        scope_empty;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      wss_lane_map #(.BANKS(BANKS), .ADDR_W(ADDR_W)) u_map (
         .addr  (addr_q[l*ADDR_W +: ADDR_W]),
         .width (width_q),
         .banks (lane_banks[l]),
         .row   (lane_rows[l])
      );
   end

   always_comb begin
      if (width_q == ACC_W128) scope = pass_q ? ~LO_MASK : LO_MASK;
      else                     scope = '1;
   end

   assign cand        = pend_q & scope;
   assign scope_empty = ((cand & ~served) == '0);

   wss_pick #(.LANES(LANES), .BANKS(BANKS), .ROW_W(ROW_W)) u_pick (
      .cand       (cand),
      .lane_banks (lane_banks),
      .lane_rows  (lane_rows),
      .served     (served),
      .bank_en    (bank_en),
      .bank_row   (bank_row),
      .bank_src   (bank_src)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         pass_q     <= 1'b0;
         write_q    <= 1'b0;
         done_q     <= 1'b0;
         width_q    <= ACC_W32;
         pend_q     <= '0;
         addr_q     <= '0;
         cnt_q      <= '0;
         done_cnt_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q && req_valid) begin
            addr_q  <= req_addr;
            width_q <= acc_width_e'(req_width);
            write_q <= req_write;
            pend_q  <= req_active;
            pass_q  <= 1'b0;
            cnt_q   <= '0;
            if (req_active == '0) begin
               done_q     <= 1'b1;
               done_cnt_q <= '0;
            end else begin
               busy_q <= 1'b1;
            end
         end else if (busy_q) begin
            pend_q <= pend_q & ~served;
            cnt_q  <= cnt_q + 1'b1;
            if (scope_empty) begin
               if (width_q == ACC_W128 && !pass_q) begin
                  pass_q <= 1'b1;
               end else begin
                  busy_q     <= 1'b0;
                  done_q     <= 1'b1;
                  done_cnt_q <= cnt_q + 1'b1;
               end
            end
         end
      end
   end

   assign req_ready    = !busy_q;
   assign txn_valid    = busy_q;
   assign txn_lanes    = busy_q ? served : '0;
   assign txn_bank_en  = busy_q ? bank_en : '0;
   assign txn_bank_row = bank_row;
   assign txn_bank_src = bank_src;
   assign txn_write    = write_q;
   assign done         = done_q;
   assign done_count   = done_cnt_q;

   // R3: only pending lanes may be served
   p_served_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> ((served & ~pend_q) == '0));
   // R9: a non-empty scope always makes progress
   p_progress_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cand != '0) |-> (served != '0));
   // R9: back-to-back transactions never serve the same lane twice
   p_no_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (txn_valid && $past(txn_valid)) |-> ((txn_lanes & $past(txn_lanes)) == '0));
   // R5: the first pass of a wide access stays in the lower half
   p_half_scope_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && width_q == ACC_W128 && !pass_q) |-> ((served & ~LO_MASK) == '0));
   // R8: an empty request finishes at once with a zero count
   p_empty_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_active == '0) |=> (done && done_count == '0 && !txn_valid));
endmodule

// File: tb/tb_wss_splitter.sv
`timescale 1ns/1ps
module tb_wss_splitter;
   localparam int L = 32, B = 32, AW = 16, RW = 9, SW = 5, CW = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [1:0] req_width = 2'd0;
   logic [L-1:0] req_active = '0;
   logic [L*AW-1:0] req_addr = '0;
   logic req_ready, txn_valid, txn_write, done;
   logic [L-1:0] txn_lanes;
   logic [B-1:0] txn_bank_en;
   logic [B*RW-1:0] txn_bank_row;
   logic [B*SW-1:0] txn_bank_src;
   logic [CW-1:0] done_count;

   always #2 clk = ~clk;

   wss_splitter dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_active(req_active), .req_addr(req_addr), .req_width(req_width),
      .req_write(req_write), .txn_valid(txn_valid), .txn_lanes(txn_lanes),
      .txn_bank_en(txn_bank_en), .txn_bank_row(txn_bank_row),
      .txn_bank_src(txn_bank_src), .txn_write(txn_write), .done(done),
      .done_count(done_count)
   );

   int n_chk = 0, n_fail = 0;
   logic [AW-1:0] a [L];
   logic [L-1:0] lg_lanes [64];
   logic [B-1:0] lg_en [64];
   logic [B*RW-1:0] lg_row [64];
   logic [B*SW-1:0] lg_src [64];
   logic lg_wr [64];
   int got_n, got_cnt;
   bit hs_ok;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(4.0 * 150000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
   end

   // Offers one request, collects its transactions until done.
   task automatic run(input logic [L-1:0] act, input logic [1:0] w, input logic wr);
      int n;
      for (int i = 0; i < L; i++) req_addr[i*AW +: AW] = a[i];
      req_active = act; req_width = w; req_write = wr; req_valid = 1'b1;
      hs_ok = req_ready;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      n = 0;
      if (act != '0 && !txn_valid) hs_ok = 1'b0;
      while (!done && n < 64) begin
         if (!txn_valid || req_ready) hs_ok = 1'b0;
         lg_lanes[n] = txn_lanes; lg_en[n] = txn_bank_en;
         lg_row[n] = txn_bank_row; lg_src[n] = txn_bank_src; lg_wr[n] = txn_write;
         n++;
         @(negedge clk);
      end
      if (!req_ready) hs_ok = 1'b0;
      got_n = n;
      got_cnt = int'(done_count);
      @(negedge clk);
      if (done) hs_ok = 1'b0;
   endtask

   function automatic int gcd(input int x, input int y);
      int p = x, q = y, r;
      while (q != 0) begin r = p % q; p = q; q = r; end
      return p;
   endfunction

   task automatic stride_test(input int w, input int s);
      int U, nb, Lp, passes, P, nper, exp_n, h, t, u, bk, first;
      longint em;
      bit ok;
      string rq;
      U = (w == 0) ? 32 : (w == 1) ? 16 : 8;
      nb = 32 / U;
      Lp = (w == 2) ? 16 : 32;
      passes = (w == 2) ? 2 : 1;
      P = (s == 0) ? Lp : U / gcd(s, U);
      nper = (s == 0) ? 1 : Lp / P;
      exp_n = passes * nper;
      rq = (s == 0) ? "R2" : (w == 0) ? "R3" : (w == 1) ? "R7" : "R5";
      for (int i = 0; i < L; i++) a[i] = AW'(i * s * nb * 4);
      run('1, 2'(w), 1'b0);
      chk(got_cnt == exp_n, rq, "done_count", got_cnt, exp_n);
      chk(got_n == exp_n && hs_ok, "R9", "txn cycles/handshake", got_n, exp_n);
      if (w == 2 && s == 1) chk(got_cnt == 4, "R6", "wide lane*16 count", got_cnt, 4);
      if (w == 1 && s == 1) chk(got_cnt == 2, "R7", "64-bit lane*8 count", got_cnt, 2);
      for (int k = 0; k < exp_n && k < got_n; k++) begin
         h = k / nper; t = k % nper;
         first = h * Lp + t * P;
         em = ((64'd1 << P) - 1) << first;
         chk(lg_lanes[k] == L'(em), rq, "served lanes", lg_lanes[k], em);
         ok = ($countones(lg_en[k]) == ((s == 0) ? nb : P * nb));
         for (int i = first; i < first + P; i++) begin
            u = i * s;
            for (int j = 0; j < nb; j++) begin
               bk = (u % U) * nb + j;
               if (!lg_en[k][bk]) ok = 0;
               if (lg_row[k][bk*RW +: RW] != RW'(u / U)) ok = 0;
               if (lg_src[k][bk*SW +: SW] != SW'((s == 0) ? first : i)) ok = 0;
            end
         end
         chk(ok, "R1", "bank rows/sources", k, s);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R10", "ready in reset", req_ready, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !txn_valid && !done, "R10", "idle after reset",
          {req_ready, txn_valid, done}, 3'b100);

      for (int w = 0; w < 3; w++)
         for (int s = 0; s < 32; s++) stride_test(w, s);

      // R8: empty request
      for (int i = 0; i < L; i++) a[i] = '0;
      run('0, 2'd0, 1'b0);
      chk(got_n == 0 && got_cnt == 0 && hs_ok, "R8", "empty request", got_n, 0);

      // R8: inactive lanes ignored (all lanes hit bank 0 on distinct rows)
      for (int i = 0; i < L; i++) a[i] = AW'(i * 128);
      run(32'h0000_0021, 2'd0, 1'b0);
      chk(got_cnt == 2, "R8", "count with two active", got_cnt, 2);
      chk(lg_lanes[0] == 32'h1 && lg_lanes[1] == 32'h20, "R8", "served order",
          {lg_lanes[1], lg_lanes[0]}, {32'h20, 32'h1});

      // R4 / R11: lanes 3,7,9,16 write byte 0x40
      for (int i = 0; i < L; i++) a[i] = AW'(i * 4);
      a[3] = 16'h40; a[7] = 16'h40; a[9] = 16'h40;
      run('1, 2'd0, 1'b1);
      chk(got_cnt == 1, "R4", "write count", got_cnt, 1);
      chk(lg_src[0][16*SW +: SW] == 5'd3, "R4", "writer of bank 16",
          lg_src[0][16*SW +: SW], 3);
      chk($countones(lg_en[0]) == 29, "R4", "banks enabled", $countones(lg_en[0]), 29);
      chk(lg_wr[0] == 1'b1, "R11", "write flag", lg_wr[0], 1);

      // R5: wide access with only upper lanes active
      for (int i = 0; i < L; i++) a[i] = '0;
      a[25] = 16'h10;
      run(32'h0210_0000, 2'd2, 1'b0);
      chk(got_cnt == 2, "R5", "upper-only count", got_cnt, 2);
      chk(lg_lanes[0] == '0 && lg_en[0] == '0, "R5", "empty lower pass",
          lg_en[0], 0);
      chk(lg_lanes[1] == 32'h0210_0000 && lg_en[1] == 32'h0000_00ff, "R5",
          "upper pass", lg_en[1], 32'hff);

      // R1: sub-access address bits ignored (64-bit, lane*8+5)
      for (int i = 0; i < L; i++) a[i] = AW'(i * 8 + 5);
      run('1, 2'd1, 1'b0);
      chk(got_cnt == 2, "R1", "low bits ignored", got_cnt, 2);

      // R1: width code 3 behaves as 32-bit (stride 1 word -> 1 txn)
      for (int i = 0; i < L; i++) a[i] = AW'(i * 4);
      run('1, 2'd3, 1'b0);
      chk(got_cnt == 1 && lg_en[0] == '1, "R1", "code 3 as 32-bit", got_cnt, 1);

      summary();
   end
endmodule